// File: doc/BRIEF.md
# Logical Device Configuration Register File

This block stores the resource settings of up to eight logical devices inside a multi-function I/O controller. Software reaches it through three byte-wide I/O locations on a small address bus. A write to the index location picks a configuration register. A write to the data location stores into that register. A read from the readback location returns the register that is currently picked.

One register holds a logical device number. It chooses which device's bank the remaining registers refer to. Each bank holds:

- an activate byte, whose bit 0 turns the device on;
- a 16-bit base address, split into a high and a low byte;
- an IRQ number;
- a DMA channel.

The block drives the settings of every device continuously on its outputs. It also drives a one-cycle change pulse per device, which tells the attached peripheral to remap itself after a write has actually altered its settings.

An external enable input gates all access. While it is low, every bus cycle is ignored, but the stored configuration is kept.

Top module: `ldcfg_regfile`

## Requirements
- R1: After reset, every device bank holds its default settings, the register index is 0x00 and the device number is 0. The defaults (active, base, IRQ, DMA) are: device 0 = 1, 0x3F0, 6, 2; device 1 = 1, 0x3F8, 4, 0; device 2 = 1, 0x2F8, 3, 0; device 3 = 1, 0x378, 7, 0; device 5 = 1, 0x200, 0, 0; devices 4, 6 and 7 = 0, 0x000, 0, 0.
- R2: A bus write to address 0x279 sets the register index, and a bus write to 0x A79 stores into the indexed register. While `busRd` is high at address 0x3E3, `busRdata` shows the indexed register in the same cycle. In every other cycle `busRdata` is 0xFF.
- R3: Register 0x07 is the device number. Only bits 2:0 of the written byte are kept, so writing 0xFD reads back as 0x05.
- R4: For the selected device, the registers map as follows: 0x30 is the activate byte (bit 0 drives `devActive`), 0x60 is the base high byte, 0x61 is the base low byte, 0x70 is the IRQ and 0x74 is the DMA. A write changes only the selected device's bank.
- R5: A data write to one of the bank registers raises bit d of `devChange` for exactly one cycle, in the cycle after the write, where d is the selected device. This happens only if the new byte differs from the stored byte in at least one bit. An equal write raises no pulse.
- R6: The IRQ output of device 3 reads 0xFF when its stored IRQ is above 15. The register still reads back the raw value. Other devices output their IRQ unchanged.
- R7: Reading an unimplemented index returns 0xFF. Writing an unimplemented index changes no state and raises no pulse.
- R8: While `cfgEnable` is low, index and data writes are ignored and reads return 0xFF. The stored values, including the index and the device number, stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Enables access to the configuration locations |
| busAddr | input | 12 | I/O address of the current bus cycle |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational), 0xFF when not reading |
| devActive | output | 8 | Bit d: device d is activated |
| devBase | output | 128 | Base address of device d at bits 16d+15:16d |
| devIrq | output | 64 | IRQ of device d at bits 8d+7:8d |
| devDma | output | 64 | DMA channel of device d at bits 8d+7:8d |
| devChange | output | 8 | One-cycle remap pulse for device d |

## Verification
A table of writes visits every bank field on several different devices. Each write is followed by a readback and a check of the pulse, which separates a missing write, a write landing in the wrong bank and a wrong field mapping. The table includes writes that repeat the stored byte and writes to an unused index. These separate a pulse raised on any write from one raised only on a real difference. Directed tests then probe the 15/16 boundary of the device 3 IRQ against a non-clamped device, the masking of the device-number byte, and a burst of accesses while disabled. The disabled burst is followed by a readback that exposes any index, device number or bank value that moved.

// File: rtl/ldcfg_pkg.sv
package ldcfg_pkg;

  // Configuration register indices; software decodes these, so they are fixed.
  localparam logic [7:0] REG_LDN    = 8'h07;
  localparam logic [7:0] REG_ACT    = 8'h30;
  localparam logic [7:0] REG_BASEHI = 8'h60;
  localparam logic [7:0] REG_BASELO = 8'h61;
  localparam logic [7:0] REG_IRQ    = 8'h70;
  localparam logic [7:0] REG_DMA    = 8'h74;

  typedef enum logic [2:0] {
    FLD_NONE,
    FLD_LDN,
    FLD_ACT,
    FLD_BASEHI,
    FLD_BASELO,
    FLD_IRQ,
    FLD_DMA
  } fieldT;

  // Strobes from control to datapath
  typedef struct packed {
    logic       ldnWr;
    logic       fieldWr;
    fieldT      field;
    logic [7:0] wdata;
  } strobeT;

  typedef struct packed {
    logic [7:0]  act;
    logic [15:0] base;
    logic [7:0]  irq;
    logic [7:0]  dma;
  } bankT;

  function automatic bankT devDefault(int idx);
    bankT b;
    b = '0;
    case (idx)
      0: b = '{act: 8'h01, base: 16'h03F0, irq: 8'd6, dma: 8'd2};
      1: b = '{act: 8'h01, base: 16'h03F8, irq: 8'd4, dma: 8'd0};
      2: b = '{act: 8'h01, base: 16'h02F8, irq: 8'd3, dma: 8'd0};
      3: b = '{act: 8'h01, base: 16'h0378, irq: 8'd7, dma: 8'd0};
      5: b = '{act: 8'h01, base: 16'h0200, irq: 8'd0, dma: 8'd0};
      default: b = '0;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/ldcfg_ctrl.sv
module ldcfg_ctrl
  import ldcfg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 12'h279,
  parameter logic [ADDR_W-1:0] DATA_PORT = 12'hA79,
  parameter logic [ADDR_W-1:0] READ_PORT = 12'h3E3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  output strobeT            stb,
  output fieldT             rdSel,
  output logic              rdEn
);

  logic [7:0] idxQ;
  logic       idxWr;
  logic       dataWr;
  fieldT      wrField;

  function automatic fieldT decodeIdx(logic [7:0] i);
    fieldT f;
    case (i)
      REG_LDN:    f = FLD_LDN;
      REG_ACT:    f = FLD_ACT;
      REG_BASEHI: f = FLD_BASEHI;
      REG_BASELO: f = FLD_BASELO;
      REG_IRQ:    f = FLD_IRQ;
      REG_DMA:    f = FLD_DMA;
      default:    f = FLD_NONE;
    endcase
    return f;
  endfunction

  assign idxWr   = cfgEnable && busWr && (busAddr == IDX_PORT);
  assign dataWr  = cfgEnable && busWr && (busAddr == DATA_PORT);
  assign wrField = decodeIdx(idxQ);

  always_ff @(posedge clk) begin
    if (!rstN)      idxQ <= 8'h00;
    else if (idxWr) idxQ <= busWdata;
  end

  always_comb begin
    stb.ldnWr   = dataWr && (wrField == FLD_LDN);
    stb.fieldWr = dataWr && (wrField != FLD_LDN) && (wrField != FLD_NONE);
    stb.field   = wrField;
    stb.wdata   = busWdata;
  end

  assign rdSel = wrField;
  assign rdEn  = cfgEnable && busRd && (busAddr == READ_PORT);

  // R8: no datapath strobe while access is disabled
  assert_no_strobe_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |-> !(stb.ldnWr || stb.fieldWr));

  // R8: the index survives a disabled cycle
  assert_index_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> $stable(idxQ));

endmodule

// File: rtl/ldcfg_datapath.sv
module ldcfg_datapath
  import ldcfg_pkg::*;
#(
  parameter int NUM_DEV  = 8,
  parameter int DEV_BITS = $clog2(NUM_DEV),
  parameter int LPT_DEV  = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeT                stb,
  input  fieldT                 rdSel,
  output logic [7:0]            rdValue,
  output logic [NUM_DEV-1:0]    devActive,
  output logic [NUM_DEV*16-1:0] devBase,
  output logic [NUM_DEV*8-1:0]  devIrq,
  output logic [NUM_DEV*8-1:0]  devDma,
  output logic [NUM_DEV-1:0]    devChange
);

  localparam int IRQ_MAX = 15;

  logic [DEV_BITS-1:0] ldn;
  logic [NUM_DEV-1:0][7:0]  actV;
  logic [NUM_DEV-1:0][15:0] baseV;
  logic [NUM_DEV-1:0][7:0]  irqV;
  logic [NUM_DEV-1:0][7:0]  dmaV;

  always_ff @(posedge clk) begin
    if (!rstN)          ldn <= '0;
    else if (stb.ldnWr) ldn <= stb.wdata[DEV_BITS-1:0];
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : gBank
    bankT bankQ;
    bankT bankNxt;
    logic hit;
    logic diff;
    logic chgQ;

    assign hit = stb.fieldWr && (ldn == DEV_BITS'(g));

    always_comb begin
      bankNxt = bankQ;
      case (stb.field)
        FLD_ACT:    bankNxt.act        = stb.wdata;
        FLD_BASEHI: bankNxt.base[15:8] = stb.wdata;
        FLD_BASELO: bankNxt.base[7:0]  = stb.wdata;
        FLD_IRQ:    bankNxt.irq        = stb.wdata;
        FLD_DMA:    bankNxt.dma        = stb.wdata;
        default:    bankNxt            = bankQ;
      endcase
    end

    assign diff = (bankNxt != bankQ);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankQ <= devDefault(g);
        chgQ  <= 1'b0;
      end else begin
        chgQ <= hit && diff;
        if (hit) bankQ <= bankNxt;
      end
    end

    assign actV[g]  = bankQ.act;
    assign baseV[g] = bankQ.base;
    assign irqV[g]  = bankQ.irq;
    assign dmaV[g]  = bankQ.dma;

    assign devActive[g]          = bankQ.act[0];
    assign devBase[16*g +: 16]   = bankQ.base;
    assign devDma[8*g +: 8]      = bankQ.dma;
    assign devChange[g]          = chgQ;

    if (g == LPT_DEV) begin : gClampIrq
      assign devIrq[8*g +: 8] = (bankQ.irq > 8'(IRQ_MAX)) ? 8'hFF : bankQ.irq;
    end else begin : gRawIrq
      assign devIrq[8*g +: 8] = bankQ.irq;
    end
  end

  always_comb begin
    case (rdSel)
      FLD_LDN:    rdValue = 8'(ldn);
      FLD_ACT:    rdValue = actV[ldn];
      FLD_BASEHI: rdValue = baseV[ldn][15:8];
      FLD_BASELO: rdValue = baseV[ldn][7:0];
      FLD_IRQ:    rdValue = irqV[ldn];
      FLD_DMA:    rdValue = dmaV[ldn];
      default:    rdValue = 8'hFF;
    endcase
  end

  // R5: at most one device pulses at a time
  assert_change_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(devChange));

  // R5: a pulse follows a bank-field write
  assert_change_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|devChange) |-> $past(stb.fieldWr));

  // R3: the device number keeps the low bits of the written byte
  assert_ldn_lowbits_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.ldnWr) |-> (ldn == $past(stb.wdata[DEV_BITS-1:0])));

  // R4: banks hold their values when no field write happened
  assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.fieldWr) |-> ($stable(actV) && $stable(baseV) && $stable(irqV) && $stable(dmaV)));

endmodule

// File: rtl/ldcfg_regfile.sv
module ldcfg_regfile
  import ldcfg_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int ADDR_W  = 12,
  parameter int LPT_DEV = 3,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 12'h279,
  parameter logic [ADDR_W-1:0] DATA_PORT = 12'hA79,
  parameter logic [ADDR_W-1:0] READ_PORT = 12'h3E3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgEnable,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWr,
  input  logic                  busRd,
  input  logic [7:0]            busWdata,
  output logic [7:0]            busRdata,
  output logic [NUM_DEV-1:0]    devActive,
  output logic [NUM_DEV*16-1:0] devBase,
  output logic [NUM_DEV*8-1:0]  devIrq,
  output logic [NUM_DEV*8-1:0]  devDma,
  output logic [NUM_DEV-1:0]    devChange
);

  localparam int DEV_BITS = $clog2(NUM_DEV);

  strobeT     stb;
  fieldT      rdSel;
  logic       rdEn;
  logic [7:0] rdValue;

  ldcfg_ctrl #(
    .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT), .READ_PORT(READ_PORT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
    .stb(stb), .rdSel(rdSel), .rdEn(rdEn)
  );

  ldcfg_datapath #(
    .NUM_DEV(NUM_DEV), .DEV_BITS(DEV_BITS), .LPT_DEV(LPT_DEV)
  ) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .rdValue(rdValue),
    .devActive(devActive), .devBase(devBase), .devIrq(devIrq),
    .devDma(devDma), .devChange(devChange)
  );

  assign busRdata = rdEn ? rdValue : 8'hFF;

  // R2 / R8: read data idles at all ones outside an enabled readback
  assert_idle_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgEnable && busRd && (busAddr == READ_PORT)) |-> (busRdata == 8'hFF));

endmodule

// File: tb/sim_ldcfg_regfile.sv
`timescale 1ns/1ps
module sim_ldcfg_regfile;

  localparam int NDEV = 8;
  localparam logic [11:0] A_IDX  = 12'h279;
  localparam logic [11:0] A_DATA = 12'hA79;
  localparam logic [11:0] A_RD   = 12'h3E3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnable = 1'b1;
  logic [11:0] busAddr = '0;
  logic busWr = 1'b0;
  logic busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [NDEV-1:0] devActive;
  logic [NDEV*16-1:0] devBase;
  logic [NDEV*8-1:0] devIrq;
  logic [NDEV*8-1:0] devDma;
  logic [NDEV-1:0] devChange;

  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  ldcfg_regfile u0 (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata),
    .devActive(devActive), .devBase(devBase), .devIrq(devIrq),
    .devDma(devDma), .devChange(devChange)
  );

  // {dev[2:0], index[7:0], data[7:0], expected readback[7:0], expected pulse}
  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {3'd1, 8'h60, 8'h02, 8'h02, 1'b1},
    {3'd1, 8'h61, 8'hE8, 8'hE8, 1'b1},
    {3'd1, 8'h61, 8'hE8, 8'hE8, 1'b0},
    {3'd2, 8'h70, 8'h05, 8'h05, 1'b1},
    {3'd0, 8'h74, 8'h01, 8'h01, 1'b1},
    {3'd3, 8'h30, 8'h00, 8'h00, 1'b1},
    {3'd4, 8'h30, 8'h01, 8'h01, 1'b1},
    {3'd7, 8'h60, 8'h00, 8'h00, 1'b0},
    {3'd6, 8'h74, 8'h03, 8'h03, 1'b1},
    {3'd5, 8'h61, 8'h01, 8'h01, 1'b1},
    {3'd2, 8'h45, 8'h12, 8'hFF, 1'b0},
    {3'd0, 8'h30, 8'h01, 8'h01, 1'b0}
  };

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic busWrite(logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    busRd = 1'b0;
  endtask

  task automatic selectReg(logic [2:0] dev, logic [7:0] idx);
    busWrite(A_IDX, 8'h07);
    busWrite(A_DATA, {5'b0, dev});
    busWrite(A_IDX, idx);
  endtask

  function automatic logic [47:0] expDefault(int d);
    // {active(8), base(16), irq(8), dma(8), pad(8)}
    case (d)
      0: return {8'd1, 16'h03F0, 8'd6, 8'd2, 8'd0};
      1: return {8'd1, 16'h03F8, 8'd4, 8'd0, 8'd0};
      2: return {8'd1, 16'h02F8, 8'd3, 8'd0, 8'd0};
      3: return {8'd1, 16'h0378, 8'd7, 8'd0, 8'd0};
      5: return {8'd1, 16'h0200, 8'd0, 8'd0, 8'd0};
      default: return 48'd0;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [47:0] e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int d = 0; d < NDEV; d++) begin
      e = expDefault(d);
      check("R1", "active", devActive[d], e[40]);
      check("R1", "base", devBase[16*d +: 16], e[39:24]);
      check("R1", "irq", devIrq[8*d +: 8], e[23:16]);
      check("R1", "dma", devDma[8*d +: 8], e[15:8]);
    end
    check("R1", "no pulse", devChange, 0);
    busRead(A_RD, rd);
    check("R7", "reset index 0x00 unimplemented", rd, 8'hFF);
    busWrite(A_IDX, 8'h07);
    busRead(A_RD, rd);
    check("R1", "reset device number", rd, 8'h00);

    // R2: idle and wrong-address reads
    #1 check("R2", "idle read", busRdata, 8'hFF);
    busRead(A_IDX, rd);
    check("R2", "read at index address", rd, 8'hFF);

    // R4 / R5 / R7: vector table
    for (int i = 0; i < NV; i++) begin
      logic [2:0] vd;
      logic [7:0] vi, vw, vr;
      logic vp;
      {vd, vi, vw, vr, vp} = VEC[i];
      selectReg(vd, vi);
      busWrite(A_DATA, vw);
      check("R5", $sformatf("pulse vec %0d", i), devChange, vp ? (8'd1 << vd) : 8'd0);
      @(negedge clk);
      check("R5", $sformatf("pulse gone vec %0d", i), devChange, 0);
      busRead(A_RD, rd);
      check("R4", $sformatf("readback vec %0d", i), rd, vr);
    end
    check("R4", "dev1 base", devBase[16*1 +: 16], 16'h02E8);
    check("R4", "dev1 irq untouched", devIrq[8*1 +: 8], 8'd4);
    check("R4", "dev2 irq", devIrq[8*2 +: 8], 8'd5);
    check("R4", "dev0 dma", devDma[8*0 +: 8], 8'd1);
    check("R4", "active map", devActive, 8'b0011_0111);
    check("R4", "dev5 base", devBase[16*5 +: 16], 16'h0201);
    check("R4", "dev6 dma", devDma[8*6 +: 8], 8'd3);
    check("R7", "dev2 base untouched", devBase[16*2 +: 16], 16'h02F8);

    // R3: device number masking
    busWrite(A_IDX, 8'h07);
    busWrite(A_DATA, 8'hFD);
    busRead(A_RD, rd);
    check("R3", "ldn masked", rd, 8'h05);
    check("R3", "no pulse on ldn write", devChange, 0);

    // R6: device 3 IRQ clamp boundary
    selectReg(3'd3, 8'h70);
    busWrite(A_DATA, 8'h20);
    check("R6", "dev3 irq 0x20", devIrq[8*3 +: 8], 8'hFF);
    busRead(A_RD, rd);
    check("R6", "dev3 raw readback", rd, 8'h20);
    busWrite(A_DATA, 8'h0F);
    check("R6", "dev3 irq 15", devIrq[8*3 +: 8], 8'h0F);
    busWrite(A_DATA, 8'h10);
    check("R6", "dev3 irq 16", devIrq[8*3 +: 8], 8'hFF);
    selectReg(3'd2, 8'h70);
    busWrite(A_DATA, 8'h20);
    check("R6", "dev2 irq not clamped", devIrq[8*2 +: 8], 8'h20);

    // R8: disabled access
    cfgEnable = 1'b0;
    busWrite(A_DATA, 8'h99);
    check("R8", "no pulse disabled", devChange, 0);
    busWrite(A_IDX, 8'h07);
    busWrite(A_DATA, 8'h06);
    busWrite(A_IDX, 8'h60);
    busRead(A_RD, rd);
    check("R8", "read disabled", rd, 8'hFF);
    check("R8", "dev2 irq kept", devIrq[8*2 +: 8], 8'h20);
    check("R8", "dev6 base kept", devBase[16*6 +: 16], 16'h0000);
    cfgEnable = 1'b1;
    busRead(A_RD, rd);
    check("R8", "index and ldn kept", rd, 8'h20);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule